// File: doc/BRIEF.md
# Memory-Mapped Command Engine

This block executes remote read and write requests against an on-chip 32-bit Wishbone bus. Upstream logic has already stripped the network framing. It hands the block a request header: identity bytes, command, start address, byte length, flags, a tracking id and a node number. For writes it also supplies a valid/ready stream of 32-bit payload words. The engine checks the header, performs one bus cycle per 32-bit word, and returns exactly one typed reply for each request. A successful read returns DATA, a successful write returns ACK, and anything rejected or failed returns NACK.

Words read from the bus leave on a valid/ready stream as they arrive. The reply header is presented after the last bus word, because only then is the outcome known. A consumer that sees a NACK discards any read words that came before it. One flag bit selects the addressing mode. In range mode the address steps through memory or registers. In constant mode every word uses the same address, which suits FIFO-style ports. A per-word watchdog and the bus error input both end a transfer early with a NACK.

Top module: `mmio_cmd_engine`

## Requirements
- R1: A header is taken in when `req_valid` and `req_ready` are both high. `req_ready` is high only while the engine is idle. Command codes are READ=1 and WRITE=2 on input, and DATA=3, ACK=4 and NACK=5 on `rsp_cmd`. The identity bytes must equal the parameters MAGIC (default 0xC5) and VERSION (default 0x01).
- R2: A header with a wrong identity byte, or a command other than READ or WRITE, gets a NACK. It causes no bus cycle and consumes no payload word.
- R3: A length of zero, a length that is not a multiple of 4, or a length above MAX_BYTES (default 8192) gets a NACK with no bus cycle. A length of exactly 8192 is accepted.
- R4: An accepted WRITE consumes exactly length/4 payload words. Each word is written in its own bus cycle with WE=1 and SEL=4'b1111, and a fully acknowledged write ends with an ACK reply.
- R5: An accepted READ performs length/4 read cycles and emits each returned word on `rd_data` in bus order. A fully acknowledged read ends with a DATA reply whose length equals the requested length.
- R6: When flags bit 0 is 0 (range mode) the word address starts at the request address and rises by 4 after each acknowledged word. When flags bit 0 is 1 (constant mode) every word uses the request address.
- R7: Every reply echoes the request's address, flags, tracking id and node number. DATA and ACK replies carry the request length, and NACK replies carry length 0.
- R8: A bus error stops the transfer and the reply becomes NACK. For a write, the engine still consumes the payload words that remain, so the total consumed equals length/4.
- R9: If a word is not acknowledged, the strobe stays high for exactly TIMEOUT cycles (default 256). The transfer then stops and the reply is NACK.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the reply fields hold steady. While `rd_valid` is high and `rd_ready` is low, `rd_data` holds steady.
- R11: During reset the engine is idle: `req_ready` is high, and `rsp_valid`, `rd_valid`, `wr_ready` and `wb_cyc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request header present |
| req_ready | output | 1 | Engine idle and taking a header |
| req_magic | input | 8 | First identity byte |
| req_version | input | 8 | Second identity byte |
| req_cmd | input | 8 | Request command code |
| req_addr | input | 32 | Start byte address |
| req_len | input | 16 | Transfer length in bytes |
| req_flags | input | 8 | Flags; bit 0 selects constant addressing |
| req_tid | input | 16 | Tracking id |
| req_node | input | 8 | Node number |
| wr_valid | input | 1 | Write payload word present |
| wr_ready | output | 1 | Engine taking a payload word |
| wr_data | input | 32 | Write payload word |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_sel | output | 4 | Byte selects |
| wb_adr | output | 32 | Bus byte address |
| wb_dat_o | output | 32 | Bus write data |
| wb_dat_i | input | 32 | Bus read data |
| wb_ack | input | 1 | Bus acknowledge |
| wb_err | input | 1 | Bus error |
| rd_valid | output | 1 | Read word present |
| rd_ready | input | 1 | Consumer takes read word |
| rd_data | output | 32 | Read word |
| rsp_valid | output | 1 | Reply header present |
| rsp_ready | input | 1 | Consumer takes reply |
| rsp_cmd | output | 8 | Reply command code |
| rsp_addr | output | 32 | Echoed address |
| rsp_len | output | 16 | Reply length in bytes |
| rsp_flags | output | 8 | Echoed flags |
| rsp_tid | output | 16 | Echoed tracking id |
| rsp_node | output | 8 | Echoed node number |

## Verification
The assertions assume a well-behaved bus slave. It raises acknowledge or error only while the strobe is high, never both at once, and for a single cycle. They also assume the header stays steady while it is offered, and that an accepted write is followed by exactly length/4 payload words while a rejected request is followed by none. The bench's slave model answers in the cycle after it counts its configured wait, then drops its reply on the next cycle. The bench pushes payload only for write requests that pass the header checks. Error and silence are injected only through that slave, at chosen word positions.

// File: rtl/mmce_pkg.sv
package mmce_pkg;
   localparam logic [7:0] CMD_READ  = 8'd1;
   localparam logic [7:0] CMD_WRITE = 8'd2;
   localparam logic [7:0] CMD_DATA  = 8'd3;
   localparam logic [7:0] CMD_ACK   = 8'd4;
   localparam logic [7:0] CMD_NACK  = 8'd5;

   typedef struct packed {
      logic [7:0]  magic;
      logic [7:0]  version;
      logic [7:0]  cmd;
      logic [31:0] addr;
      logic [15:0] len;
      logic [7:0]  flags;
      logic [15:0] tid;
      logic [7:0]  node;
   } hdr_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_EVAL, ST_FETCH, ST_BUS, ST_RDOUT, ST_DRAIN, ST_RESP
   } state_t;
endpackage

// File: rtl/mmce_hdr_check.sv
module mmce_hdr_check
   import mmce_pkg::*;
#(
   parameter logic [7:0] MAGIC     = 8'hC5,
   parameter logic [7:0] VERSION   = 8'h01,
   parameter int         MAX_BYTES = 8192,
   parameter bit         CHECK_ID  = 1'b1
) (
   input  logic [7:0]  magic,
   input  logic [7:0]  version,
   input  logic [7:0]  cmd,
   input  logic [15:0] len,
   output logic        ok
);
   logic id_ok, cmd_ok, len_ok;

   generate
      if (CHECK_ID) begin : g_id
         assign id_ok = (magic == MAGIC) && (version == VERSION);
      end else begin : g_no_id
         assign id_ok = 1'b1;
      end
   endgenerate

   assign cmd_ok = (cmd == CMD_READ) || (cmd == CMD_WRITE);
   assign len_ok = (len != 16'd0) && (len[1:0] == 2'b00) &&
                   ({16'd0, len} <= 32'(MAX_BYTES));
   assign ok     = id_ok && cmd_ok && len_ok;
endmodule

// File: rtl/mmce_addr_gen.sv
module mmce_addr_gen #(
   parameter int AW   = 32,
   parameter int STEP = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic          const_mode,
   input  logic [AW-1:0] base,
   output logic [AW-1:0] adr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   adr <= '0;
      else if (load)                adr <= base;
      else if (step && !const_mode) adr <= adr + AW'(STEP);
   end

   // R6: range mode advances by one word per acknowledged word
   assert_range_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !const_mode) |=> (adr == $past(adr) + AW'(STEP)));
   // R6: constant mode keeps the address fixed
   assert_const_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && const_mode) |=> $stable(adr));
endmodule

// File: rtl/mmce_wdog.sv
module mmce_wdog #(
   parameter int TIMEOUT = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic kick,
   output logic expire
);
   localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

   logic [CW-1:0] cnt;

   assign expire = run && !kick && (cnt == CW'(TIMEOUT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (!run || kick || expire)  cnt <= '0;
      else                              cnt <= cnt + 1'b1;
   end

   // R9: the wait count never passes the limit
   assert_wdog_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ({{(32-CW){1'b0}}, cnt} < 32'(TIMEOUT)));
endmodule

// File: rtl/mmio_cmd_engine.sv
module mmio_cmd_engine
   import mmce_pkg::*;
#(
   parameter logic [7:0] MAGIC     = 8'hC5,
   parameter logic [7:0] VERSION   = 8'h01,
   parameter int         MAX_BYTES = 8192,
   parameter int         TIMEOUT   = 256,
   parameter int         CONST_BIT = 0,
   parameter bit         CHECK_ID  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic [7:0]  req_magic,
   input  logic [7:0]  req_version,
   input  logic [7:0]  req_cmd,
   input  logic [31:0] req_addr,
   input  logic [15:0] req_len,
   input  logic [7:0]  req_flags,
   input  logic [15:0] req_tid,
   input  logic [7:0]  req_node,
   input  logic        wr_valid,
   output logic        wr_ready,
   input  logic [31:0] wr_data,
   output logic        wb_cyc,
   output logic        wb_stb,
   output logic        wb_we,
   output logic [3:0]  wb_sel,
   output logic [31:0] wb_adr,
   output logic [31:0] wb_dat_o,
   input  logic [31:0] wb_dat_i,
   input  logic        wb_ack,
   input  logic        wb_err,
   output logic        rd_valid,
   input  logic        rd_ready,
   output logic [31:0] rd_data,
   output logic        rsp_valid,
   input  logic        rsp_ready,
   output logic [7:0]  rsp_cmd,
   output logic [31:0] rsp_addr,
   output logic [15:0] rsp_len,
   output logic [7:0]  rsp_flags,
   output logic [15:0] rsp_tid,
   output logic [7:0]  rsp_node
);
   localparam int MAX_WORDS = MAX_BYTES / 4;
   localparam int WCW       = $clog2(MAX_WORDS + 1);

   generate
      if (MAX_BYTES < 4 || (MAX_BYTES % 4) != 0 || MAX_BYTES > 65532) begin : g_bad_len
         $error("MAX_BYTES must be a multiple of 4 between 4 and 65532");
      end
      if (TIMEOUT < 2) begin : g_bad_tmo
         $error("TIMEOUT must be at least 2");
      end
      if (CONST_BIT < 0 || CONST_BIT > 7) begin : g_bad_bit
         $error("CONST_BIT must select a bit of the flags byte");
      end
   endgenerate

   state_t           state;
   hdr_t             hdr, req_in;
   logic [WCW-1:0]   words_left;
   logic [31:0]      wdat;
   logic             fail, hdr_ok, is_write, in_bus, expire, abort, last_word;

   assign req_in    = {req_magic, req_version, req_cmd, req_addr,
                       req_len, req_flags, req_tid, req_node};
   assign is_write  = (hdr.cmd == CMD_WRITE);
   assign in_bus    = (state == ST_BUS);
   assign abort     = wb_err || expire;
   assign last_word = (words_left == WCW'(1));

   mmce_hdr_check #(.MAGIC(MAGIC), .VERSION(VERSION), .MAX_BYTES(MAX_BYTES),
                    .CHECK_ID(CHECK_ID)) u_check (
      .magic(hdr.magic), .version(hdr.version), .cmd(hdr.cmd),
      .len(hdr.len), .ok(hdr_ok));

   mmce_addr_gen #(.AW(32), .STEP(4)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(state == ST_EVAL),
      .step(in_bus && wb_ack), .const_mode(hdr.flags[CONST_BIT]),
      .base(hdr.addr), .adr(wb_adr));

   mmce_wdog #(.TIMEOUT(TIMEOUT)) u_wdog (
      .clk(clk), .rst_n(rst_n), .run(in_bus),
      .kick(wb_ack || wb_err), .expire(expire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         hdr        <= '0;
         words_left <= '0;
         wdat       <= '0;
         rd_data    <= '0;
         fail       <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (req_valid) begin
               hdr   <= req_in;
               fail  <= 1'b0;
               state <= ST_EVAL;
            end
            ST_EVAL: begin
               words_left <= WCW'(hdr.len[15:2]);
               if (!hdr_ok) begin
                  fail  <= 1'b1;
                  state <= ST_RESP;
               end else begin
                  state <= is_write ? ST_FETCH : ST_BUS;
               end
            end
            ST_FETCH: if (wr_valid) begin
               wdat  <= wr_data;
               state <= ST_BUS;
            end
            ST_BUS: begin
               if (wb_ack) begin
                  words_left <= words_left - 1'b1;
                  if (!is_write) begin
                     rd_data <= wb_dat_i;
                     state   <= ST_RDOUT;
                  end else begin
                     state <= last_word ? ST_RESP : ST_FETCH;
                  end
               end else if (abort) begin
                  fail <= 1'b1;
                  if (is_write && !last_word) begin
                     words_left <= words_left - 1'b1;
                     state      <= ST_DRAIN;
                  end else begin
                     state <= ST_RESP;
                  end
               end
            end
            ST_RDOUT: if (rd_ready) begin
               state <= (words_left == '0) ? ST_RESP : ST_BUS;
            end
            ST_DRAIN: if (wr_valid) begin
               words_left <= words_left - 1'b1;
               if (last_word) state <= ST_RESP;
            end
            ST_RESP: if (rsp_ready) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign wr_ready  = (state == ST_FETCH) || (state == ST_DRAIN);
   assign wb_cyc    = in_bus;
   assign wb_stb    = in_bus;
   assign wb_we     = in_bus && is_write;
   assign wb_sel    = 4'hF;
   assign wb_dat_o  = wdat;
   assign rd_valid  = (state == ST_RDOUT);
   assign rsp_valid = (state == ST_RESP);
   assign rsp_cmd   = fail ? CMD_NACK : (is_write ? CMD_ACK : CMD_DATA);
   assign rsp_len   = fail ? 16'd0 : hdr.len;
   assign rsp_addr  = hdr.addr;
   assign rsp_flags = hdr.flags;
   assign rsp_tid   = hdr.tid;
   assign rsp_node  = hdr.node;

   // R2 R3: a rejected header never opens a bus cycle
   assert_no_bus_on_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EVAL && !hdr_ok) |=> !wb_cyc);
   // R4: write data stays put while a word waits for its acknowledge
   assert_wdata_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_stb && wb_we && !wb_ack && !abort) |=> $stable(wb_dat_o));
   // R1: a reply only ever carries one of the three reply codes
   assert_reply_type_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_cmd == CMD_DATA || rsp_cmd == CMD_ACK || rsp_cmd == CMD_NACK));
   // R10: a stalled reply keeps its content
   assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_cmd) && $stable(rsp_tid)
                                     && $stable(rsp_len)));
   // R10: a stalled read word keeps its value
   assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
   // R1: no new header is taken while a reply is pending
   assert_one_at_a_time_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (!req_ready && !wb_cyc));
endmodule

// File: tb/mmio_cmd_engine_bench.sv
module mmio_cmd_engine_bench;
   import mmce_pkg::*;

   localparam logic [7:0] MG = 8'hC5;
   localparam logic [7:0] VR = 8'h01;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        req_valid = 1'b0, req_ready;
   logic [7:0]  req_magic = '0, req_version = '0, req_cmd = '0, req_flags = '0, req_node = '0;
   logic [31:0] req_addr = '0;
   logic [15:0] req_len = '0, req_tid = '0;
   logic        wr_valid = 1'b0, wr_ready;
   logic [31:0] wr_data = '0;
   logic        wb_cyc, wb_stb, wb_we;
   logic [3:0]  wb_sel;
   logic [31:0] wb_adr, wb_dat_o;
   logic [31:0] wb_dat_i = '0;
   logic        wb_ack = 1'b0, wb_err = 1'b0;
   logic        rd_valid, rd_ready = 1'b1;
   logic [31:0] rd_data;
   logic        rsp_valid, rsp_ready = 1'b1;
   logic [7:0]  rsp_cmd, rsp_flags, rsp_node;
   logic [31:0] rsp_addr;
   logic [15:0] rsp_len, rsp_tid;

   mmio_cmd_engine u_mmio_cmd_engine (.*);

   int n_cmp = 0, n_bad = 0;
   int cyc_n = 0, rsp_seen = 0, consumed = 0;
   int ack_delay = 0, err_at = -1, word_idx = 0, wait_cnt = 0, stb_cycles = 0, bus_words = 0;
   int rsp_stall = 0;
   bit no_ack = 0, chk_bus = 1, rd_bp = 0;
   logic [31:0] mem [256];
   logic [31:0] wr_q [$];
   logic [64:0] exp_bus [$];
   logic [31:0] exp_rd [$];
   logic [87:0] exp_rsp [$];
   logic        prev_rv = 0, prev_rr = 0, prev_dv = 0, prev_dr = 0;
   logic [87:0] prev_rsp = '0;
   logic [31:0] prev_rd = '0;

   task automatic chk(input bit c, input string tag, input logic [95:0] act, input logic [95:0] exp);
      n_cmp++;
      if (!c) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [87:0] rsp_bits();
      return {rsp_cmd, rsp_addr, rsp_len, rsp_flags, rsp_tid, rsp_node};
   endfunction

   always @(negedge clk) begin
      cyc_n++;
      if (cyc_n > 150000) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cyc_n);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
      if (rst_n) begin
         if (wb_ack || wb_err) begin
            wb_ack = 0; wb_err = 0; wait_cnt = 0;
         end else if (wb_cyc && wb_stb) begin
            stb_cycles++;
            if (!no_ack && wait_cnt >= ack_delay) begin
               bus_words++;
               if (word_idx == err_at) wb_err = 1;
               else begin
                  wb_ack = 1;
                  if (chk_bus) begin
                     if (exp_bus.size() == 0)
                        chk(0, "R4 unexpected bus word", {63'd0, wb_we, wb_adr}, 96'd0);
                     else begin
                        logic [64:0] e;
                        e = exp_bus.pop_front();
                        chk(wb_we == e[64] && wb_adr == e[63:32] && wb_sel == 4'hF &&
                            (!wb_we || wb_dat_o == e[31:0]), "R6 bus word",
                            {31'd0, wb_we, wb_adr, wb_dat_o}, {31'd0, e});
                     end
                  end
                  if (wb_we) mem[wb_adr[9:2]] = wb_dat_o;
                  else wb_dat_i = mem[wb_adr[9:2]];
               end
               word_idx++;
            end else wait_cnt++;
         end
      end
      wr_valid = (wr_q.size() > 0);
      wr_data  = wr_valid ? wr_q[0] : 32'd0;
      rd_ready = rd_bp ? (cyc_n % 3 == 0) : 1'b1;
      rsp_ready = (rsp_stall == 0);
      if (rsp_valid && rsp_stall > 0) rsp_stall--;
      #1;
      if (prev_rv && !prev_rr)
         chk(rsp_valid && rsp_bits() == prev_rsp, "R10 reply held", {7'd0, rsp_valid, rsp_bits()}, {8'd1, prev_rsp});
      if (prev_dv && !prev_dr)
         chk(rd_valid && rd_data == prev_rd, "R10 read word held", {63'd0, rd_valid, rd_data}, {64'd1, prev_rd});
      if (wr_valid && wr_ready) begin
         void'(wr_q.pop_front());
         consumed++;
      end
      if (rd_valid && rd_ready) begin
         if (exp_rd.size() == 0) chk(0, "R5 unexpected read word", {64'd0, rd_data}, 96'd0);
         else begin
            logic [31:0] e;
            e = exp_rd.pop_front();
            chk(rd_data == e, "R5 read word", {64'd0, rd_data}, {64'd0, e});
         end
      end
      if (rsp_valid && rsp_ready) begin
         if (exp_rsp.size() == 0) chk(0, "R7 unexpected reply", {8'd0, rsp_bits()}, 96'd0);
         else begin
            logic [87:0] e;
            e = exp_rsp.pop_front();
            chk(rsp_bits() == e, "R7 reply header", {8'd0, rsp_bits()}, {8'd0, e});
         end
         rsp_seen++;
      end
      prev_rv = rsp_valid; prev_rr = rsp_ready; prev_rsp = rsp_bits();
      prev_dv = rd_valid;  prev_dr = rd_ready;  prev_rd = rd_data;
   end

   task automatic send(input logic [7:0] mg, input logic [7:0] vr, input logic [7:0] cm,
                       input logic [31:0] ad, input logic [15:0] ln, input logic [7:0] fl,
                       input logic [15:0] tid, input logic [7:0] nd);
      int target;
      target = rsp_seen + 1;
      word_idx = 0; wait_cnt = 0;
      @(negedge clk);
      req_magic = mg; req_version = vr; req_cmd = cm; req_addr = ad;
      req_len = ln; req_flags = fl; req_tid = tid; req_node = nd; req_valid = 1;
      #2;
      while (!req_ready) begin @(negedge clk); #2; end
      @(negedge clk);
      req_valid = 0;
      while (rsp_seen < target) @(negedge clk);
      #2;
   endtask

   task automatic do_write(input logic [31:0] ad, input int n, input logic [7:0] fl,
                           input logic [15:0] tid, input logic [7:0] nd);
      for (int i = 0; i < n; i++) begin
         logic [31:0] d;
         d = {tid, 16'(i)} ^ 32'h5A5A_0F0F;
         wr_q.push_back(d);
         exp_bus.push_back({1'b1, fl[0] ? ad : ad + 32'(4 * i), d});
      end
      exp_rsp.push_back({CMD_ACK, ad, 16'(4 * n), fl, tid, nd});
      send(MG, VR, CMD_WRITE, ad, 16'(4 * n), fl, tid, nd);
      chk(wr_q.size() == 0 && exp_bus.size() == 0, "R4 every payload word written",
          96'(wr_q.size() + exp_bus.size()), 96'd0);
   endtask

   task automatic do_read(input logic [31:0] ad, input int n, input logic [7:0] fl,
                          input logic [15:0] tid, input logic [7:0] nd);
      for (int i = 0; i < n; i++) begin
         logic [31:0] a;
         a = fl[0] ? ad : ad + 32'(4 * i);
         exp_bus.push_back({1'b0, a, 32'd0});
         exp_rd.push_back(mem[a[9:2]]);
      end
      exp_rsp.push_back({CMD_DATA, ad, 16'(4 * n), fl, tid, nd});
      send(MG, VR, CMD_READ, ad, 16'(4 * n), fl, tid, nd);
      chk(exp_rd.size() == 0 && exp_bus.size() == 0, "R5 every word read and returned",
          96'(exp_rd.size() + exp_bus.size()), 96'd0);
   endtask

   task automatic do_reject(input logic [7:0] mg, input logic [7:0] vr, input logic [7:0] cm,
                            input logic [15:0] ln, input string tag);
      int bw, c0;
      bw = bus_words; c0 = consumed;
      exp_rsp.push_back({CMD_NACK, 32'h0000_0040, 16'd0, 8'h00, 16'h0BAD, 8'h07});
      send(mg, vr, cm, 32'h0000_0040, ln, 8'h00, 16'h0BAD, 8'h07);
      chk(bus_words == bw && consumed == c0, tag, 96'(bus_words - bw + consumed - c0), 96'd0);
   endtask

   initial begin
      int bw, c0;
      for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + 32'(i);
      repeat (2) @(negedge clk);
      #2;
      // R11: reset state
      chk(req_ready && !rsp_valid && !rd_valid && !wr_ready && !wb_cyc, "R11 reset state",
          {91'd0, req_ready, rsp_valid, rd_valid, wr_ready, wb_cyc}, 96'h10);
      @(negedge clk); rst_n = 1;
      @(negedge clk); #2;
      chk(req_ready && !wb_cyc, "R11 idle after reset", {94'd0, req_ready, wb_cyc}, 96'h2);

      // R4 R6 R7: range writes, then read back
      do_write(32'h0000_0040, 4, 8'h00, 16'h1111, 8'h01);
      do_read (32'h0000_0040, 4, 8'h00, 16'h2222, 8'h02);
      // R6: constant-address port access
      do_write(32'h0000_0080, 3, 8'h01, 16'h3333, 8'h03);
      do_read (32'h0000_0080, 2, 8'h81, 16'h4444, 8'h04);
      // R10: stalled reply and stalled read words with a slow slave
      ack_delay = 3; rd_bp = 1; rsp_stall = 6;
      do_read (32'h0000_0040, 5, 8'h00, 16'h5555, 8'h05);
      ack_delay = 0; rd_bp = 0;
      // R2: bad identity and bad commands
      do_reject(8'h00, VR, CMD_READ, 16'd4, "R2 wrong magic, no bus, no payload");
      do_reject(MG, 8'h02, CMD_WRITE, 16'd4, "R2 wrong version, no bus, no payload");
      do_reject(MG, VR, CMD_DATA, 16'd4, "R2 reply code as request");
      do_reject(MG, VR, 8'd0, 16'd4, "R2 command zero");
      // R3: length rules
      do_reject(MG, VR, CMD_READ, 16'd0, "R3 zero length");
      do_reject(MG, VR, CMD_READ, 16'd6, "R3 length not multiple of 4");
      do_reject(MG, VR, CMD_READ, 16'd8196, "R3 length above limit");
      do_read (32'h0000_0010, 2048, 8'h01, 16'h6666, 8'h06);  // R3 maximum accepted

      // R8: bus error on the third of four write words, rest drained
      chk_bus = 0; err_at = 2; bw = bus_words; c0 = consumed;
      for (int i = 0; i < 4; i++) wr_q.push_back(32'hE000_0000 + 32'(i));
      exp_rsp.push_back({CMD_NACK, 32'h0000_0100, 16'd0, 8'h00, 16'h7777, 8'h08});
      send(MG, VR, CMD_WRITE, 32'h0000_0100, 16'd16, 8'h00, 16'h7777, 8'h08);
      chk(consumed - c0 == 4, "R8 remaining write payload drained", 96'(consumed - c0), 96'd4);
      chk(bus_words - bw == 3, "R8 no bus word after error", 96'(bus_words - bw), 96'd3);
      // R8: bus error on second read word
      err_at = 1; bw = bus_words;
      exp_rd.push_back(mem[8'h40]);
      exp_rsp.push_back({CMD_NACK, 32'h0000_0100, 16'd0, 8'h00, 16'h8888, 8'h09});
      send(MG, VR, CMD_READ, 32'h0000_0100, 16'd12, 8'h00, 16'h8888, 8'h09);
      chk(exp_rd.size() == 0 && bus_words - bw == 2, "R8 read stops at error",
          96'(bus_words - bw), 96'd2);
      err_at = -1;
      // R9: silent slave
      no_ack = 1; stb_cycles = 0;
      exp_rsp.push_back({CMD_NACK, 32'h0000_0020, 16'd0, 8'h00, 16'h9999, 8'h0A});
      send(MG, VR, CMD_READ, 32'h0000_0020, 16'd4, 8'h00, 16'h9999, 8'h0A);
      chk(stb_cycles == 256, "R9 strobe held for the timeout", 96'(stb_cycles), 96'd256);
      no_ack = 0; chk_bus = 1;
      // R1: engine takes new requests after failures
      do_write(32'h0000_0200, 2, 8'h00, 16'hAAAA, 8'h0B);
      do_read (32'h0000_0200, 2, 8'h00, 16'hBBBB, 8'h0C);
      chk(exp_rsp.size() == 0, "R1 one reply per request", 96'(exp_rsp.size()), 96'd0);

      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule